// File: doc/BRIEF.md
# Result Queue Redundancy Checker

This block sits between a leading, speculative thread and a trailing, checking thread of a two-thread core. The leading side writes each retired instruction into an in-order queue, together with the value it produced and a flag that marks the result as untrustworthy. An untrustworthy result comes from a long-latency load, or from an instruction that depends on one. The trailing side takes the entries in their original order and executes each one again. It returns every new result on a simple result port.

A trustworthy entry is executed once, and the new value must equal the recorded one. An untrustworthy entry is sent to the trailing side twice, and the two new values must equal each other. A result reaches architectural state only when its check agrees. A disagreement can come from a soft error or from a wrong guess by the leading thread. In either case the block reports the failing queue slot for one cycle and throws away every queued entry. It then holds a rewind request for a fixed number of cycles, during which neither side may move.

Top module: `rq_redundancy_checker`

## Requirements
- R1: Entries are offered on the issue port strictly in the order they were accepted on the push port. The head entry is offered (`issue_valid` high) whenever the queue holds an entry, no re-execution is outstanding and no rewind is active.
- R2: The queue holds `DEPTH` entries (default 512). `full` is high exactly when `DEPTH` entries are held. A push is accepted only in a cycle where `push_ready` is high, and `push_ready` is low when full.
- R3: An entry pushed with `push_inv` = 0 is offered once (`issue_second` = 0). The result returned for it is compared with the result recorded at push time.
- R4: An entry pushed with `push_inv` = 1 is offered twice: first with `issue_second` = 0, then with `issue_second` = 1. The two returned results are compared with each other, and the result recorded at push time has no effect.
- R5: When a check agrees, the entry leaves the queue. In the cycle after the returning `rex_valid`, `commit_valid` is high for one cycle with the entry's instruction and the returned result. No result is committed any other way.
- R6: When a check disagrees, `mismatch` is high for exactly one cycle, in the cycle after the returning `rex_valid`. In that cycle `mismatch_idx` holds the slot of the failing entry. Slots are numbered 0, 1, 2, … in push order from reset and again from each squash, wrapping at `DEPTH`.
- R7: A disagreement discards every queued entry, including any push offered in the same cycle, so the queue is empty once the rewind ends.
- R8: `rewind_req` rises together with `mismatch` and stays high for `REWIND_CYCLES` cycles (default 8). While it is high, `push_ready` and `issue_valid` are low. `push_ready` is also low in the cycle a disagreement is detected.
- R9: A pulse on `rex_valid` while no issued entry awaits its result is ignored: nothing is committed, no mismatch is raised, and the head entry does not change.
- R10: After reset the queue is empty, `push_ready` is high, and `issue_valid`, `commit_valid`, `mismatch`, `rewind_req` and `full` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_valid | input | 1 | Leading side offers a retired instruction |
| push_insn | input | INSN_W | Instruction word of the offered entry |
| push_result | input | DATA_W | Result produced by the leading side |
| push_inv | input | 1 | Leading result is untrustworthy |
| push_ready | output | 1 | Push is accepted this cycle if offered |
| full | output | 1 | Queue holds DEPTH entries |
| issue_valid | output | 1 | Head entry offered for re-execution |
| issue_ready | input | 1 | Trailing side takes the offered entry |
| issue_insn | output | INSN_W | Instruction word of the head entry |
| issue_second | output | 1 | Offer is the second copy of an untrustworthy entry |
| rex_valid | input | 1 | Re-executed result returns |
| rex_result | input | DATA_W | Re-executed result value |
| commit_valid | output | 1 | A checked result commits |
| commit_insn | output | INSN_W | Instruction of the committing entry |
| commit_result | output | DATA_W | Committed result value |
| mismatch | output | 1 | One-cycle pulse on a failed check |
| mismatch_idx | output | $clog2(DEPTH) | Slot of the failing entry |
| rewind_req | output | 1 | Rewind to committed state in progress |

## Verification
The hardest case to reach is a disagreement that lands while the leading side is still pushing and the queue is partly full. The squash must then drop the queued entries and the push of that same cycle, and slot numbering must restart from zero. The stimulus plants one wrong leading result at a chosen position in a stream, and plants one wrong second copy in a stream that mixes both kinds of entry. A behavioural queue model predicts every output on every cycle through the rewind and after it. A separate run fills the queue to its limit with the trailing side stalled, then drains it, to show the back-pressure.

// File: rtl/rq_pkg.sv
// Shared types of the result queue checker.
// Assumes nothing beyond IEEE 1800-2017.
package rq_pkg;
    // Check sequencer state: waiting to hand out the head, or waiting for its result.
    typedef enum logic {
        CK_ISSUE = 1'b0,
        CK_WAIT  = 1'b1
    } ck_state_e;
endpackage

// File: rtl/rq_fifo.sv
// Circular in-order entry store with a flush.
// Assumes: the caller never writes when full, never reads when empty,
// and never writes in a cycle that flushes.
module rq_fifo #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 65,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [AW-1:0]    rd_idx,
    output logic             empty,
    output logic             full
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;

    // Write the pushed entry into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // Advance pointers and occupancy; a flush returns everything to slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (wr_en && !rd_en)      count <= count + 1'b1;
            else if (rd_en && !wr_en) count <= count - 1'b1;
        end
    end

    assign rd_data = mem[rd_ptr];
    assign rd_idx  = rd_ptr;
    assign empty   = (count == '0);
    assign full    = (count == CAP);

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_en);
    a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
    a_r7_no_write_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !wr_en);
endmodule

// File: rtl/rq_check_ctrl.sv
// Check sequencer: hands the head entry to the trailing side, collects the
// re-executed result(s), and decides commit or squash.
// Assumes: only one re-execution outstanding at a time; the head stays
// stable while a result is awaited.
module rq_check_ctrl
    import rq_pkg::*;
#(
    parameter int INSN_W = 32,
    parameter int DATA_W = 32,
    parameter int AW     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid,
    input  logic [INSN_W-1:0] head_insn,
    input  logic [DATA_W-1:0] head_res,
    input  logic              head_inv,
    input  logic [AW-1:0]     head_idx,
    input  logic              hold,
    input  logic              issue_ready,
    input  logic              rex_valid,
    input  logic [DATA_W-1:0] rex_result,
    output logic              issue_valid,
    output logic [INSN_W-1:0] issue_insn,
    output logic              issue_second,
    output logic              pop,
    output logic              squash,
    output logic              commit_valid,
    output logic [INSN_W-1:0] commit_insn,
    output logic [DATA_W-1:0] commit_result,
    output logic              mismatch,
    output logic [AW-1:0]     mismatch_idx
);
    ck_state_e         state;
    logic              second;
    logic [DATA_W-1:0] first_res;
    logic              take, resolve, want_copy, agree;
    logic [DATA_W-1:0] golden;

    // Decode handshakes and the comparison for the head entry.
    always_comb begin
        issue_valid = (state == CK_ISSUE) && head_valid && !hold;
        take        = issue_valid && issue_ready;
        resolve     = (state == CK_WAIT) && rex_valid;
        want_copy   = head_inv && !second;
        golden      = head_inv ? first_res : head_res;
        agree       = (golden == rex_result);
        pop         = resolve && !want_copy && agree;
        squash      = resolve && !want_copy && !agree;
    end

    assign issue_insn   = head_insn;
    assign issue_second = second;

    // Sequence issue / wait and remember the first copy of an untrusted entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= CK_ISSUE;
            second    <= 1'b0;
            first_res <= '0;
        end else if (take) begin
            state <= CK_WAIT;
        end else if (resolve) begin
            state  <= CK_ISSUE;
            second <= want_copy;
            if (want_copy) first_res <= rex_result;
        end
    end

    // Register the commit and mismatch reports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_valid  <= 1'b0;
            commit_insn   <= '0;
            commit_result <= '0;
            mismatch      <= 1'b0;
            mismatch_idx  <= '0;
        end else begin
            commit_valid <= pop;
            mismatch     <= squash;
            if (pop) begin
                commit_insn   <= head_insn;
                commit_result <= rex_result;
            end
            if (squash) mismatch_idx <= head_idx;
        end
    end

    a_r4_second_only_untrusted: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_second) |-> head_inv);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> !mismatch);
    a_r5_commit_excludes_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> !mismatch);
    a_r1_head_present_when_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CK_WAIT) |-> head_valid);
endmodule

// File: rtl/rq_rewind_timer.sv
// Holds the rewind request for a fixed number of cycles after a squash.
// Assumes: a new start never arrives while the timer runs.
module rq_rewind_timer #(
    parameter int CYCLES = 8,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CW-1:0] left;

    // Load on start, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          left <= '0;
        else if (start)      left <= CW'(CYCLES);
        else if (left != '0) left <= left - 1'b1;
    end

    assign busy = (left != '0);

    a_r8_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/rq_redundancy_checker.sv
// Top: in-order result queue between a leading and a trailing thread with
// redundancy check, commit, squash and timed rewind request.
// Assumes: the trailing side returns exactly one result per taken issue.
module rq_redundancy_checker #(
    parameter int DEPTH         = 512,
    parameter int INSN_W        = 32,
    parameter int DATA_W        = 32,
    parameter int REWIND_CYCLES = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [INSN_W-1:0] push_insn,
    input  logic [DATA_W-1:0] push_result,
    input  logic              push_inv,
    output logic              push_ready,
    output logic              full,
    output logic              issue_valid,
    input  logic              issue_ready,
    output logic [INSN_W-1:0] issue_insn,
    output logic              issue_second,
    input  logic              rex_valid,
    input  logic [DATA_W-1:0] rex_result,
    output logic              commit_valid,
    output logic [INSN_W-1:0] commit_insn,
    output logic [DATA_W-1:0] commit_result,
    output logic              mismatch,
    output logic [AW-1:0]     mismatch_idx,
    output logic              rewind_req
);
    localparam int EW = INSN_W + DATA_W + 1;

    logic          squash, pop, empty, wr_en;
    logic [EW-1:0] head;
    logic [AW-1:0] head_idx;

    // Accept a push only with room, outside rewind, and not while squashing.
    always_comb begin
        push_ready = !full && !rewind_req && !squash;
        wr_en      = push_valid && push_ready;
    end

    rq_fifo #(.DEPTH(DEPTH), .WIDTH(EW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (squash),
        .wr_en   (wr_en),
        .wr_data ({push_inv, push_insn, push_result}),
        .rd_en   (pop),
        .rd_data (head),
        .rd_idx  (head_idx),
        .empty   (empty),
        .full    (full)
    );

    rq_check_ctrl #(.INSN_W(INSN_W), .DATA_W(DATA_W), .AW(AW)) u_check (
        .clk           (clk),
        .rst_n         (rst_n),
        .head_valid    (!empty),
        .head_insn     (head[DATA_W +: INSN_W]),
        .head_res      (head[DATA_W-1:0]),
        .head_inv      (head[EW-1]),
        .head_idx      (head_idx),
        .hold          (rewind_req),
        .issue_ready   (issue_ready),
        .rex_valid     (rex_valid),
        .rex_result    (rex_result),
        .issue_valid   (issue_valid),
        .issue_insn    (issue_insn),
        .issue_second  (issue_second),
        .pop           (pop),
        .squash        (squash),
        .commit_valid  (commit_valid),
        .commit_insn   (commit_insn),
        .commit_result (commit_result),
        .mismatch      (mismatch),
        .mismatch_idx  (mismatch_idx)
    );

    rq_rewind_timer #(.CYCLES(REWIND_CYCLES)) u_rewind (
        .clk   (clk),
        .rst_n (rst_n),
        .start (squash),
        .busy  (rewind_req)
    );

    a_r8_rewind_with_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |-> rewind_req);
    a_r8_no_issue_in_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_req |-> (!issue_valid && !push_ready));
    a_r7_empty_after_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |-> !issue_valid);
endmodule

// File: tb/test_rq_redundancy_checker.sv
module test_rq_redundancy_checker;
    localparam int DEPTH  = 512;
    localparam int REWIND = 8;
    localparam int AW     = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        push_valid = 0, push_inv = 0, issue_ready = 0, rex_valid = 0;
    logic [31:0] push_insn = 0, push_result = 0, rex_result = 0;
    logic        push_ready, full, issue_valid, issue_second, commit_valid, mismatch, rewind_req;
    logic [31:0] issue_insn, commit_insn, commit_result;
    logic [AW-1:0] mismatch_idx;

    rq_redundancy_checker #(.DEPTH(DEPTH), .INSN_W(32), .DATA_W(32), .REWIND_CYCLES(REWIND)) i_rq_redundancy_checker (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_insn(push_insn),
        .push_result(push_result), .push_inv(push_inv), .push_ready(push_ready), .full(full),
        .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_insn(issue_insn),
        .issue_second(issue_second), .rex_valid(rex_valid), .rex_result(rex_result),
        .commit_valid(commit_valid), .commit_insn(commit_insn), .commit_result(commit_result),
        .mismatch(mismatch), .mismatch_idx(mismatch_idx), .rewind_req(rewind_req)
    );

    int checks = 0, failures = 0, cyc = 0;
    int commits_seen = 0, mism_seen = 0;
    bit done = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] fval(input logic [31:0] x);
        return x * 32'd3 + 32'd7;
    endfunction

    // Scenario knobs
    int          lead_next = 256, lead_end = 256;
    bit          inv_mode = 0, trail_on = 0, stray = 0;
    logic [31:0] bad_lead = 0, bad_inv = 0;

    // Behavioural reference model
    typedef struct { logic [31:0] insn; logic [31:0] res; bit inv; int slot; } ent_t;
    ent_t        mq[$];
    bit          mwait = 0, mcopy = 0;
    logic [31:0] mfirst = 0;
    int          rew = 0, next_slot = 0;
    bit          m_commit = 0, m_mism = 0;
    logic [31:0] m_cinsn = 0, m_cres = 0;
    int          m_midx = 0;

    function automatic bit model_squash();
        logic [31:0] g;
        if (!(mwait && rex_valid)) return 0;
        if (mq[0].inv && !mcopy) return 0;
        g = mq[0].inv ? mfirst : mq[0].res;
        return g != rex_result;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); mwait = 0; mcopy = 0; rew = 0; next_slot = 0;
            m_commit = 0; m_mism = 0;
        end else begin
            bit sq, acc;
            logic [31:0] g;
            sq  = model_squash();
            acc = push_valid && (mq.size() < DEPTH) && (rew == 0) && !sq;
            m_commit = 0; m_mism = 0;
            if (mwait && rex_valid) begin
                if (mq[0].inv && !mcopy) begin
                    mfirst = rex_result; mcopy = 1; mwait = 0;
                end else begin
                    g = mq[0].inv ? mfirst : mq[0].res;
                    if (g == rex_result) begin
                        m_commit = 1; m_cinsn = mq[0].insn; m_cres = rex_result;
                        void'(mq.pop_front());
                    end else begin
                        m_mism = 1; m_midx = mq[0].slot;
                        mq.delete(); next_slot = 0;
                    end
                    mwait = 0; mcopy = 0;
                end
            end else if (!mwait && mq.size() > 0 && rew == 0 && issue_ready) begin
                mwait = 1;
            end
            if (sq) rew = REWIND;
            else if (rew > 0) rew--;
            if (acc) begin
                ent_t e;
                e.insn = push_insn; e.res = push_result; e.inv = push_inv; e.slot = next_slot;
                mq.push_back(e);
                next_slot = (next_slot + 1) % DEPTH;
                lead_next++;
            end
        end
    end

    // Per-cycle comparison of every output against the model.
    task automatic compare();
        bit ev;
        ev = !mwait && mq.size() > 0 && rew == 0;
        chk("R2", "push_ready", push_ready, (mq.size() < DEPTH) && rew == 0 && !model_squash());
        chk("R2", "full", full, mq.size() == DEPTH);
        chk("R1", "issue_valid", issue_valid, ev);
        if (ev) begin
            chk("R1", "issue_insn", issue_insn, mq[0].insn);
            chk("R4", "issue_second", issue_second, mcopy);
        end
        chk("R5", "commit_valid", commit_valid, m_commit);
        if (m_commit) begin
            chk("R5", "commit_insn", commit_insn, m_cinsn);
            chk("R5", "commit_result", commit_result, m_cres);
        end
        chk("R6", "mismatch", mismatch, m_mism);
        if (m_mism) chk("R6", "mismatch_idx", mismatch_idx, m_midx);
        chk("R8", "rewind_req", rewind_req, rew != 0);
        if (commit_valid) commits_seen++;
        if (mismatch) mism_seen++;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // One clock: drive inputs from knobs and model state, then compare.
    task automatic cycle();
        logic [31:0] ins;
        @(negedge clk);
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog cycle limit reached");
            finish_run();
        end
        ins        = 32'(lead_next);
        push_valid = lead_next < lead_end;
        push_insn  = ins;
        push_inv   = inv_mode && (lead_next % 3 == 2);
        push_result = push_inv ? (32'hDEAD0000 ^ ins) : ((ins == bad_lead) ? fval(ins) + 5 : fval(ins));
        issue_ready = trail_on;
        if (stray && !mwait) begin
            rex_valid = 1; rex_result = 32'h1234;
        end else if (trail_on && mwait) begin
            rex_valid  = 1;
            rex_result = fval(mq[0].insn);
            if (mq[0].inv && mcopy && mq[0].insn == bad_inv) rex_result = rex_result ^ 32'h1;
        end else begin
            rex_valid = 0; rex_result = 0;
        end
        #1;
        compare();
    endtask

    task automatic drain();
        for (int i = 0; i < 5000; i++) begin
            if (lead_next == lead_end && mq.size() == 0 && !mwait && rew == 0) break;
            cycle();
        end
        cycle();
    endtask

    initial begin
        #900us;
        failures++;
        $display("FAIL watchdog timeout");
        finish_run();
    end

    initial begin
        int c0, m0;
        logic [31:0] held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cycle();
        // R10: reset state
        chk("R10", "issue_valid after reset", issue_valid, 0);
        chk("R10", "push_ready after reset", push_ready, 1);
        chk("R10", "full after reset", full, 0);
        chk("R10", "rewind_req after reset", rewind_req, 0);
        chk("R10", "commit/mismatch after reset", {commit_valid, mismatch}, 0);

        // R3/R5: stream of trusted entries, all commit
        c0 = commits_seen; trail_on = 1; lead_end = lead_next + 20;
        drain();
        chk("R3", "trusted entries committed", commits_seen - c0, 20);

        // R4: mixed stream, untrusted leading results are garbage yet commit
        c0 = commits_seen; inv_mode = 1; lead_end = lead_next + 30;
        drain();
        chk("R4", "mixed entries committed", commits_seen - c0, 30);

        // R9: stray result with nothing outstanding
        trail_on = 0; lead_end = lead_next + 3;
        repeat (5) cycle();
        held = issue_insn; m0 = mism_seen; c0 = commits_seen;
        stray = 1; cycle(); stray = 0; cycle();
        chk("R9", "no commit from stray result", commits_seen - c0, 0);
        chk("R9", "no mismatch from stray result", mism_seen - m0, 0);
        chk("R9", "head unchanged after stray", issue_insn, held);
        trail_on = 1; drain();

        // R6/R7/R8: wrong leading result on a trusted entry mid-stream
        inv_mode = 0; bad_lead = 32'(lead_next + 6); lead_end = lead_next + 40;
        m0 = mism_seen;
        for (int i = 0; i < 200 && mism_seen == m0; i++) cycle();
        chk("R6", "trusted mismatch raised", mism_seen - m0, 1);
        chk("R8", "rewind_req with mismatch", rewind_req, 1);
        lead_end = lead_next;
        repeat (REWIND) cycle();
        chk("R8", "rewind ended", rewind_req, 0);
        chk("R7", "queue empty after rewind", issue_valid, 0);
        chk("R7", "push_ready after rewind", push_ready, 1);
        bad_lead = 0; lead_end = lead_next + 10;
        drain();

        // R4/R6: second copy disagrees on an untrusted entry
        inv_mode = 1;
        bad_inv = 32'(lead_next + 5 + ((2 - ((lead_next + 5) % 3) + 3) % 3));
        lead_end = lead_next + 40; m0 = mism_seen;
        for (int i = 0; i < 300 && mism_seen == m0; i++) cycle();
        chk("R4", "untrusted copy mismatch raised", mism_seen - m0, 1);
        lead_end = lead_next;
        repeat (REWIND) cycle();
        chk("R7", "queue empty after second rewind", issue_valid, 0);
        bad_inv = 0; lead_end = lead_next + 6;
        drain();

        // R2: fill to capacity with the trailing side stalled, then drain
        inv_mode = 0; trail_on = 0; lead_end = lead_next + DEPTH + 3;
        repeat (DEPTH + 10) cycle();
        chk("R2", "full at capacity", full, 1);
        chk("R2", "push_ready low when full", push_ready, 0);
        c0 = commits_seen; trail_on = 1;
        drain();
        chk("R2", "all entries drained", commits_seen - c0, DEPTH + 3);

        finish_run();
    end
endmodule